// File: doc/BRIEF.md
# Switching PWM Gate Controller

This block is the digital control and protection logic that drives the power switch of a DC-DC converter. Once per oscillator period a ramp-start strobe arms an on-latch. The latch drives the gate of the power switch. The pulse ends when the PWM comparator reports that the error signal has crossed the ramp, or when any protection flag is raised. Clearing the latch always beats arming it.

The analog parts of the converter are outside this block. These are the error amplifier, the ramp generator, the comparators and their hysteresis. Each appears here only as a synchronous single-bit input. Overcurrent limits the pulse width cycle by cycle. Overvoltage, undervoltage and overtemperature form a lockout group: while any of them is asserted, the switch is held off and cannot be re-armed. A status output reports that the converter actually switched during the last completed period and that no lockout is active.

Top module: `pwm_gate_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, `gate_on` and `status_ok` are both low.
- R2: A `ramp_start` pulse with no clear condition in that cycle drives `gate_on` high from the next cycle on.
- R3: When `cmp_trip` is high, `gate_on` is low in that same cycle. It stays low until a later `ramp_start` arms the latch again.
- R4: When `ramp_start` and a clear condition (`cmp_trip`, `oc_flag` or any lockout flag) are high in the same cycle, `gate_on` is low in that cycle and in the next.
- R5: When `oc_flag` is high, `gate_on` is low in that same cycle, and the pulse does not resume within the period.
- R6: While any of `ov_flag`, `uv_flag` or `ot_flag` is high, `gate_on` is low, and a `ramp_start` in such a cycle does not arm the latch.
- R7: After a protection flag clears in the middle of a period, `gate_on` stays low until the next `ramp_start` with no clear condition.
- R8: If `cmp_trip` is high in every cycle, `gate_on` never goes high (zero duty).
- R9: Each `ramp_start` closes a period. From the next cycle on, `status_ok` is high exactly when `gate_on` was high in at least one cycle of the closed period, including the strobe cycle, and no lockout flag is high in the current cycle.
- R10: With no `ramp_start` and no clear condition, the latch holds its value, so `gate_on` neither rises nor falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ramp_start | input | 1 | One-cycle strobe at the start of each oscillator period |
| cmp_trip | input | 1 | PWM comparator: the error signal has crossed the ramp |
| oc_flag | input | 1 | Overcurrent at the power switch |
| ov_flag | input | 1 | Overvoltage lockout |
| uv_flag | input | 1 | Undervoltage lockout |
| ot_flag | input | 1 | Overtemperature lockout |
| gate_on | output | 1 | Gate drive for the power switch |
| status_ok | output | 1 | Converter switched in the last period and no lockout is active |

## Verification
The results are due at different points after a stimulus:
- A clear condition (comparator, overcurrent or lockout) shows on `gate_on` in the same cycle it is applied.
- A `ramp_start` shows on `gate_on` one cycle later.
- A lockout pulls `status_ok` low in the same cycle.
- A closed period shows on `status_ok` in the cycle after its closing strobe.

The bench drives inputs just after a rising edge and computes the expected output for that cycle from its own per-period model. It samples at the falling edge of the same cycle, so both same-cycle and one-cycle results are compared in the cycle they are due.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

  // Control events derived from the comparator and protection flags
  typedef struct packed {
    logic lockout;  // any whole-period lockout flag is up
    logic kill;     // latch must be cleared this cycle
    logic arm;      // latch may be set this cycle
  } pgc_ctl_t;

  // Set/reset latch with dominant clear
  function automatic logic latch_next(input logic q, input logic set_i, input logic clr_i);
    if (clr_i)      return 1'b0;
    else if (set_i) return 1'b1;
    else            return q;
  endfunction

  // Period bookkeeping: value of the "switched" record at a period boundary
  function automatic logic period_seen(input logic seen_q, input logic gate_now);
    return seen_q | gate_now;
  endfunction

endpackage

// File: rtl/pgc_fault_merge.sv
module pgc_fault_merge
  import pgc_pkg::*;
#(
  parameter int LOCK_W = 3
) (
  input  logic              ramp_start,
  input  logic              cmp_trip,
  input  logic              oc_flag,
  input  logic [LOCK_W-1:0] lock_flags,
  output pgc_ctl_t          ctl
);
  logic any_lock;

  always_comb begin
    any_lock = 1'b0;
    for (int i = 0; i < LOCK_W; i++) any_lock = any_lock | lock_flags[i];
  end

  always_comb begin
    ctl.lockout = any_lock;
    ctl.kill    = cmp_trip | oc_flag | any_lock;
    ctl.arm     = ramp_start & ~any_lock;
  end
endmodule

// File: rtl/pgc_on_latch.sv
module pgc_on_latch
  import pgc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic latch_q,
  output logic gate_on
);
  always_ff @(posedge clk) begin
    if (!rst_n) latch_q <= 1'b0;
    else        latch_q <= latch_next(latch_q, set_i, clr_i);
  end

  // Dominant reset also masks the output in the clearing cycle itself
  assign gate_on = latch_q & ~clr_i;
endmodule

// File: rtl/pgc_period_track.sv
module pgc_period_track
  import pgc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic period_start,
  input  logic gate_on,
  input  logic lockout,
  output logic last_on_q,
  output logic status_ok
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      last_on_q <= 1'b0;
    end else if (period_start) begin
      last_on_q <= period_seen(seen_q, gate_on);
      seen_q    <= 1'b0;
    end else begin
      seen_q    <= period_seen(seen_q, gate_on);
    end
  end

  assign status_ok = last_on_q & ~lockout;
endmodule

// File: rtl/pwm_gate_ctrl.sv
module pwm_gate_ctrl
  import pgc_pkg::*;
#(
  parameter int LOCK_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ramp_start,
  input  logic cmp_trip,
  input  logic oc_flag,
  input  logic ov_flag,
  input  logic uv_flag,
  input  logic ot_flag,
  output logic gate_on,
  output logic status_ok
);
  pgc_ctl_t          ctl;
  logic [LOCK_W-1:0] lock_flags;
  logic              latch_q;
  logic              last_on_q;
  logic              evt_kill;
  logic              evt_arm;
  logic              evt_lock;

  assign lock_flags = LOCK_W'({ot_flag, uv_flag, ov_flag});

  pgc_fault_merge #(.LOCK_W(LOCK_W)) u_merge (
    .ramp_start (ramp_start),
    .cmp_trip   (cmp_trip),
    .oc_flag    (oc_flag),
    .lock_flags (lock_flags),
    .ctl        (ctl)
  );

  assign evt_kill = ctl.kill;
  assign evt_arm  = ctl.arm;
  assign evt_lock = ctl.lockout;

  pgc_on_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (evt_arm),
    .clr_i   (evt_kill),
    .latch_q (latch_q),
    .gate_on (gate_on)
  );

  pgc_period_track u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_start (ramp_start),
    .gate_on      (gate_on),
    .lockout      (evt_lock),
    .last_on_q    (last_on_q),
    .status_ok    (status_ok)
  );
endmodule

// File: rtl/pwm_gate_ctrl_chk.sv
module pwm_gate_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ramp_start,
  input logic cmp_trip,
  input logic oc_flag,
  input logic gate_on,
  input logic status_ok,
  input logic latch_q,
  input logic evt_kill,
  input logic evt_lock
);
  AST_ARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_start && !evt_kill) |=> latch_q); // R2

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_start && cmp_trip) |=> !latch_q); // R4

  AST_OC_ENDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag |=> !latch_q); // R5

  AST_LOCK_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    evt_lock |-> !gate_on); // R6

  AST_NO_SELF_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_on && !ramp_start) |=> !gate_on); // R7

  AST_LOCK_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_lock |-> !status_ok); // R9
endmodule

bind pwm_gate_ctrl pwm_gate_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ramp_start (ramp_start),
  .cmp_trip   (cmp_trip),
  .oc_flag    (oc_flag),
  .gate_on    (gate_on),
  .status_ok  (status_ok),
  .latch_q    (latch_q),
  .evt_kill   (evt_kill),
  .evt_lock   (evt_lock)
);

// File: tb/pwm_gate_ctrl_tb.sv
module pwm_gate_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ramp_start = 1'b0, cmp_trip = 1'b0, oc_flag = 1'b0;
  logic ov_flag = 1'b0, uv_flag = 1'b0, ot_flag = 1'b0;
  logic gate_on, status_ok;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0] q_exp[$];
  string      q_tag[$];

  // bench model state
  logic m_latch = 1'b0, m_seen = 1'b0, m_prev = 1'b0;

  always #2 clk = ~clk;

  pwm_gate_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ramp_start(ramp_start), .cmp_trip(cmp_trip),
    .oc_flag(oc_flag), .ov_flag(ov_flag), .uv_flag(uv_flag), .ot_flag(ot_flag),
    .gate_on(gate_on), .status_ok(status_ok)
  );

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s gate/status actual=%b expected=%b at %0t", tag, act, exp_v, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected outputs
  task automatic cyc(input logic rs, input logic cmp, input logic oc,
                     input logic ov, input logic uv, input logic ot, input string tag);
    logic lock, clr, set_v, g, s;
    @(posedge clk); #1;
    ramp_start = rs; cmp_trip = cmp; oc_flag = oc;
    ov_flag = ov; uv_flag = uv; ot_flag = ot;
    lock  = ov | uv | ot;
    clr   = cmp | oc | lock;
    set_v = rs & ~lock;
    g = m_latch & ~clr;
    s = m_prev & ~lock;
    q_exp.push_back({g, s});
    q_tag.push_back(tag);
    if (rs) begin m_prev = m_seen | g; m_seen = 1'b0; end
    else    m_seen = m_seen | g;
    m_latch = clr ? 1'b0 : (set_v ? 1'b1 : m_latch);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, tag);
  endtask

  // Monitor: pops and compares at the falling edge
  always @(negedge clk) begin
    if (q_exp.size() > 0) check(q_tag.pop_front(), {gate_on, status_ok}, q_exp.pop_front());
  end

  initial begin
    #40000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with strobes applied during reset
    repeat (3) begin
      @(posedge clk); #1; ramp_start = 1'b1;
      @(negedge clk); check("R1", {gate_on, status_ok}, 2'b00);
    end
    @(posedge clk); #1; ramp_start = 1'b0; rst_n = 1'b1;
    @(negedge clk); check("R1", {gate_on, status_ok}, 2'b00);

    // R2 / R10: arm, then hold with no events
    cyc(1, 0, 0, 0, 0, 0, "R2");
    idle(4, "R10");
    // R3: comparator ends the pulse, stays off
    cyc(0, 1, 0, 0, 0, 0, "R3");
    idle(3, "R3");
    // R9: close a period in which the gate was on
    cyc(1, 0, 0, 0, 0, 0, "R9");
    idle(2, "R9");
    cyc(0, 1, 0, 0, 0, 0, "R3");
    // R4: strobe together with comparator
    cyc(1, 1, 0, 0, 0, 0, "R4");
    idle(3, "R4");
    // R9: the period just closed had no gate-on time
    cyc(1, 0, 0, 0, 0, 0, "R9");
    idle(2, "R9");
    // R5: overcurrent mid pulse, pulse not resumed
    cyc(0, 0, 1, 0, 0, 0, "R5");
    idle(3, "R5");
    // R4: strobe together with overcurrent
    cyc(1, 0, 1, 0, 0, 0, "R4");
    idle(2, "R4");
    // R6 / R7: overvoltage across a strobe, then clears mid-period
    cyc(1, 0, 0, 0, 0, 0, "R2");
    idle(2, "R2");
    cyc(0, 0, 0, 1, 0, 0, "R6");
    cyc(1, 0, 0, 1, 0, 0, "R6");
    cyc(0, 0, 0, 1, 0, 0, "R6");
    idle(3, "R7");
    cyc(1, 0, 0, 0, 0, 0, "R7");
    idle(2, "R7");
    // R6: undervoltage and overtemperature
    cyc(0, 0, 0, 0, 1, 0, "R6");
    cyc(1, 0, 0, 0, 1, 0, "R6");
    idle(2, "R7");
    cyc(1, 0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, 1, "R6");
    cyc(1, 0, 0, 0, 0, 1, "R6");
    cyc(0, 0, 0, 0, 0, 1, "R6");
    idle(2, "R7");
    cyc(1, 0, 0, 0, 0, 0, "R7");
    idle(2, "R9");
    // R8: comparator always tripped, zero duty over several periods
    for (int p = 0; p < 4; p++) begin
      cyc(1, 1, 0, 0, 0, 0, "R8");
      for (int k = 0; k < 4; k++) cyc(0, 1, 0, 0, 0, 0, "R8");
    end
    idle(2, "R9");
    // R9: a lockout masks the status in the same cycle
    cyc(1, 0, 0, 0, 0, 0, "R9");
    idle(2, "R9");
    cyc(1, 0, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 1, 0, "R9");
    idle(2, "R9");
    @(posedge clk); #1;
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule